// File: doc/BRIEF.md
# SONET Frame Synchronizer

This block sits behind a 1:4 deserializer on a SONET/SDH receive path. Every receive clock it takes one 4-bit nibble of the serial stream, where bit 0 is the earliest bit on the line. It keeps a short bit history and compares it against the A1/A1/A1/A2 framing word at all four bit offsets at once. Once a candidate boundary is found, its output nibbles are re-cut to that boundary. The boundary is trusted only after the framing word recurs at the same offset exactly one frame period later, twice in a row. At that point a four-clock sync pulse is issued and the data-valid flag is raised.

After lock, the block checks only the expected frame position. A framing word that appears anywhere else in the payload cannot move the boundary. Lock is dropped only after several consecutive expected-position checks come up empty. A frame-enable input freezes the search and holds the current alignment. A signal-detect input, compared against a polarity select, forces loss of signal. Loss of signal blanks the output to zeros and restarts the search.

Top module: `sonet_framer`

## Requirements
- R1: `los` is registered: after a clock edge it equals 1 exactly when `sig_det` and `det_pol` had different levels at that edge.
- R2: In the cycle that `los` is 1, `dout` is 4'h0 and `dout_valid` is 0. When `los` returns to 0, `dout_valid` stays 0 because the search restarts.
- R3: The framing word is the 32-bit value 32'hF6F6F628 (three A1 = 8'hF6 bytes, then A2 = 8'h28), sent most significant bit first. Within each `rx_nib`, bit 0 is earliest in time. The word is recognised at any of the four bit offsets relative to the nibble grid.
- R4: Let the framing word end in the nibble applied before edge n, with the same word ending again in the nibbles before edges n+F and n+2F (F = `FRAME_NIBS`). Then `fsync` and `dout_valid` are both 1 after edge n+2F+1.
- R5: No lock is declared when only two framing words arrive, or when successive framing words are spaced by a number of nibbles other than F.
- R6: Each assertion of `fsync` lasts exactly 4 clock cycles.
- R7: `dout_valid` is 0 before lock. After edge c with boundary offset k, `dout[i]` equals stream bit 4c-4-k+i, where stream bit 4j+i is `rx_nib[i]` applied before edge j. Here k = (4 - s mod 4) mod 4 for a framing word that starts at stream bit s.
- R8: While locked, framing words at any other position do not change the alignment of `dout`, do not drop `dout_valid` and do not raise `fsync`.
- R9: While locked, `dout_valid` falls after the 4th consecutive expected-position check that lacks the framing word. Checks fall at edges n+jF+1.
- R10: While `frame_en` is 0, no search takes place. The lock state and the alignment hold their values.
- R11: After reset, `dout` is 0 and `dout_valid`, `fsync` and `los` are all 0 (provided `sig_det` equals `det_pol`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble-rate receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_nib | input | 4 | Deserialized nibble, bit 0 earliest |
| frame_en | input | 1 | 1 = search and tracking run; 0 = hold alignment and state |
| sig_det | input | 1 | Signal-detect indication from the optics |
| det_pol | input | 1 | Polarity select; loss of signal when it differs from `sig_det` |
| dout | output | 4 | Boundary-aligned nibble, bit 0 earliest; zero during loss of signal |
| dout_valid | output | 1 | High while frame lock is held |
| fsync | output | 1 | Four-cycle pulse when lock is first declared |
| los | output | 1 | Registered loss-of-signal flag |

## Verification
The hardest condition to create is a locked receiver that then sees a genuine framing word at the wrong bit offset and wrong frame position. Reaching it needs three correctly spaced words first. The stimulus therefore comes from a bit-level stream function: main words repeat every frame at a chosen bit start, and a second "ghost" word can be switched on partway through the frame, at a different offset. The same function gives the expected aligned nibble for every cycle. Alignment is thus checked bit for bit across the whole ghost interval, the lost-lock interval and the frozen interval.

// File: rtl/sfr_pkg.sv
`timescale 1ns/1ps
package sfr_pkg;
  localparam int NIB_W  = 4;
  localparam int OFF_W  = 2;
  localparam int PAT_W  = 32;
  localparam int HIST_W = PAT_W + NIB_W - 1;
  localparam logic [PAT_W-1:0] FRAME_WORD = 32'hF6F6F628;

  typedef enum logic [1:0] {ST_HUNT, ST_VERIFY, ST_LOCKED} trk_state_t;

  // serial order: bit 0 of the nibble is earliest, so it lands highest
  function automatic logic [NIB_W-1:0] to_line_order(input logic [NIB_W-1:0] n);
    logic [NIB_W-1:0] r;
    for (int i = 0; i < NIB_W; i++) r[NIB_W-1-i] = n[i];
    return r;
  endfunction

  // lowest offset index that shows the framing word
  function automatic logic [OFF_W-1:0] first_hit(input logic [NIB_W-1:0] m);
    logic [OFF_W-1:0] r;
    r = '0;
    for (int i = NIB_W-1; i >= 0; i--) if (m[i]) r = OFF_W'(i);
    return r;
  endfunction

  // nibble cut at offset k from the history (newest bit at index 0)
  function automatic logic [NIB_W-1:0] pick_nibble(input logic [HIST_W-1:0] h,
                                                   input logic [OFF_W-1:0] k);
    logic [NIB_W-1:0] r;
    for (int i = 0; i < NIB_W; i++) r[i] = h[int'(k) + NIB_W - 1 - i];
    return r;
  endfunction
endpackage

// File: rtl/sfr_window.sv
`timescale 1ns/1ps
module sfr_window
  import sfr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] nib_in,
  input  logic [OFF_W-1:0] sel_off,
  output logic [NIB_W-1:0] match,
  output logic [NIB_W-1:0] aligned
);
  logic [HIST_W-1:0] hist;

  always_ff @(posedge clk) begin
    if (!rst_n) hist <= '0;
    else        hist <= {hist[HIST_W-NIB_W-1:0], to_line_order(nib_in)};
  end

  // one comparator per bit offset (R3)
  for (genvar k = 0; k < NIB_W; k++) begin : g_cmp
    assign match[k] = (hist[k +: PAT_W] == FRAME_WORD);
  end

  assign aligned = pick_nibble(hist, sel_off);
endmodule

// File: rtl/sfr_tracker.sv
`timescale 1ns/1ps
module sfr_tracker
  import sfr_pkg::*;
#(
  parameter int FRAME_NIBS = 77760,
  parameter int HITS_NEED  = 3,
  parameter int MISS_LIMIT = 4,
  parameter int PULSE_LEN  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             los_in,
  input  logic             frame_en,
  input  logic [NIB_W-1:0] match,
  output logic [OFF_W-1:0] off,
  output logic             locked,
  output logic             fsync
);
  localparam int CW = $clog2(FRAME_NIBS);
  localparam int HW = $clog2(HITS_NEED + 1);
  localparam int MW = $clog2(MISS_LIMIT + 1);
  localparam int PW = $clog2(PULSE_LEN + 1);

  trk_state_t  st;
  logic [CW-1:0] pos;
  logic [HW-1:0] hits;
  logic [MW-1:0] misses;
  logic [PW-1:0] pulse;

  // named events
  logic at_check, seen, any_hit, last_hit, last_miss;
  assign at_check  = (pos == CW'(FRAME_NIBS - 1));
  assign seen      = match[off];
  assign any_hit   = |match;
  assign last_hit  = (int'(hits) == HITS_NEED - 1);
  assign last_miss = (int'(misses) == MISS_LIMIT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_HUNT; pos <= '0; hits <= '0; misses <= '0; off <= '0; pulse <= '0;
    end else if (los_in) begin
      st <= ST_HUNT; pos <= '0; hits <= '0; misses <= '0; pulse <= '0;
    end else begin
      if (pulse != '0) pulse <= pulse - 1'b1;
      if (frame_en) begin
        unique case (st)
          ST_HUNT: begin
            if (any_hit) begin
              off  <= first_hit(match);
              st   <= ST_VERIFY;
              pos  <= '0;
              hits <= HW'(1);
            end
          end
          ST_VERIFY: begin
            if (at_check) begin
              pos <= '0;
              if (!seen) st <= ST_HUNT;
              else if (last_hit) begin
                st     <= ST_LOCKED;
                pulse  <= PW'(PULSE_LEN);
                misses <= '0;
              end else hits <= hits + 1'b1;
            end else pos <= pos + 1'b1;
          end
          ST_LOCKED: begin
            if (at_check) begin
              pos <= '0;
              if (seen) misses <= '0;
              else if (last_miss) st <= ST_HUNT;
              else misses <= misses + 1'b1;
            end else pos <= pos + 1'b1;
          end
          default: st <= ST_HUNT;
        endcase
      end
    end
  end

  assign locked = (st == ST_LOCKED);
  assign fsync  = (pulse != '0);

  // R6: sync pulse holds for its full length unless loss of signal cuts it
  a_r6_pulse_len: assert property (@(posedge clk) disable iff (!rst_n || los_in)
    $rose(fsync) |-> ##3 fsync);
  // R4: pulse starts only on the verify-to-locked transition
  a_r4_pulse_on_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) |-> (locked && $past(st == ST_VERIFY)));
  // R8: boundary never moves while lock is held
  a_r8_off_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(st == ST_LOCKED)) |-> $stable(off));
  // R10: disabled framing holds state, boundary and position
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_en && !los_in) |=> ($stable(st) && $stable(off) && $stable(pos)));
endmodule

// File: rtl/sonet_framer.sv
`timescale 1ns/1ps
module sonet_framer
  import sfr_pkg::*;
#(
  parameter int FRAME_NIBS = 77760,
  parameter int HITS_NEED  = 3,
  parameter int MISS_LIMIT = 4,
  parameter int PULSE_LEN  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] rx_nib,
  input  logic       frame_en,
  input  logic       sig_det,
  input  logic       det_pol,
  output logic [3:0] dout,
  output logic       dout_valid,
  output logic       fsync,
  output logic       los
);
  logic [NIB_W-1:0] match, aligned;
  logic [OFF_W-1:0] off;
  logic             locked, los_in, los_q;

  // levels disagree -> loss of signal (R1)
  assign los_in = sig_det ^ det_pol;

  sfr_window u_win (
    .clk(clk), .rst_n(rst_n), .nib_in(rx_nib), .sel_off(off),
    .match(match), .aligned(aligned)
  );

  sfr_tracker #(
    .FRAME_NIBS(FRAME_NIBS), .HITS_NEED(HITS_NEED),
    .MISS_LIMIT(MISS_LIMIT), .PULSE_LEN(PULSE_LEN)
  ) u_trk (
    .clk(clk), .rst_n(rst_n), .los_in(los_in), .frame_en(frame_en),
    .match(match), .off(off), .locked(locked), .fsync(fsync)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      los_q <= 1'b0;
      dout  <= '0;
    end else begin
      los_q <= los_in;
      dout  <= los_in ? '0 : aligned;
    end
  end

  assign los        = los_q;
  assign dout_valid = locked && !los_q;

  // R2: blanked output and no lock during loss of signal
  a_r2_los_blank: assert property (@(posedge clk) disable iff (!rst_n)
    los_q |-> (dout == '0));
  a_r2_los_hunt: assert property (@(posedge clk) disable iff (!rst_n)
    los_q |-> !locked);
  // R4: valid rises together with the sync pulse
  a_r4_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_valid) |-> fsync);
endmodule

// File: tb/sonet_framer_test.sv
`timescale 1ns/1ps
module sonet_framer_test;
  localparam int P = 24;
  localparam logic [31:0] PAT = 32'hF6F6F628;
  // stimulus/expected vectors: start bit, expected offset, polarity
  localparam int NV = 5;
  localparam int VEC [NV][3] = '{'{0,0,0}, '{1,3,1}, '{2,2,0}, '{3,1,1}, '{6,2,0}};

  logic clk = 0, rst_n = 0, frame_en = 1, sig_det = 0, det_pol = 0;
  logic [3:0] rx_nib = '0;
  logic [3:0] dout;
  logic dout_valid, fsync, los;

  int nchk = 0, nfail = 0, cyc = 0, cur = 0;
  int s_base = 0, fb = 4*P, n_frames = 1000, ghost_s = 0, ghost_from = 1 << 30;
  bit done = 0;

  always #2 clk = ~clk;

  sonet_framer #(.FRAME_NIBS(P)) uut (
    .clk(clk), .rst_n(rst_n), .rx_nib(rx_nib), .frame_en(frame_en),
    .sig_det(sig_det), .det_pol(det_pol), .dout(dout),
    .dout_valid(dout_valid), .fsync(fsync), .los(los)
  );

  function automatic logic sbit(int n);
    int p, f;
    if (n < 0) return 1'b0;
    if (n >= s_base) begin
      p = (n - s_base) % fb; f = (n - s_base) / fb;
      if (p < 32 && f < n_frames) return PAT[31-p];
    end
    if (n >= ghost_from && n >= ghost_s) begin
      p = (n - ghost_s) % fb;
      if (p < 32) return PAT[31-p];
    end
    return 1'b0;
  endfunction

  function automatic logic [3:0] exp_nib(int c, int k);
    logic [3:0] v;
    for (int i = 0; i < 4; i++) v[i] = sbit(4*c - 4 - k + i);
    return v;
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic tick();
    for (int i = 0; i < 4; i++) rx_nib[i] = sbit(4*cyc + i);
    @(posedge clk);
    @(negedge clk);
    cur = cyc;
    cyc++;
  endtask

  task automatic do_reset();
    rst_n = 0; rx_nib = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1; cyc = 0;
  endtask

  task automatic lock_up(int s, int k, int pol, int nfr, string tag);
    int n1, tgt, pulses, bad;
    s_base = s; fb = 4*P; n_frames = nfr; ghost_from = 1 << 30;
    det_pol = pol; sig_det = pol; frame_en = 1;
    do_reset();
    n1 = (s + 31) / 4; tgt = n1 + 2*P + 1; pulses = 0; bad = 0;
    while (cyc <= tgt + P) begin
      tick();
      if (cur == tgt - 1) chk(!dout_valid && !fsync, {"R7 no valid before lock ", tag}, dout_valid, 0);
      if (cur == tgt) chk(fsync && dout_valid, {"R4 lock at third word ", tag}, {fsync, dout_valid}, 3);
      if (cur >= tgt && cur <= tgt + 6 && fsync) pulses++;
      if (cur >= tgt && dout != exp_nib(cur, k)) bad++;
    end
    chk(pulses == 4, {"R6 pulse length ", tag}, pulses, 4);
    chk(bad == 0, {"R7 R3 alignment ", tag}, bad, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    int bad, vcount;
    // R11 reset state
    sig_det = 0; det_pol = 0; s_base = 0; do_reset();
    chk(dout == 4'h0, "R11 dout reset", dout, 0);
    chk(!dout_valid, "R11 valid reset", dout_valid, 0);
    chk(!fsync, "R11 fsync reset", fsync, 0);
    chk(!los, "R11 los reset", los, 0);

    // vector table: every bit offset, both polarities (R3 R4 R6 R7)
    for (int v = 0; v < NV; v++)
      lock_up(VEC[v][0], VEC[v][1], VEC[v][2], 1000, $sformatf("vec%0d", v));

    // R5: only two framing words
    s_base = 0; fb = 4*P; n_frames = 2; frame_en = 1; sig_det = 0; det_pol = 0;
    do_reset(); vcount = 0;
    repeat (5*P) begin tick(); if (dout_valid) vcount++; end
    chk(vcount == 0, "R5 two words only", vcount, 0);

    // R5: spacing off by one nibble
    fb = 4*(P+1); n_frames = 1000; do_reset(); vcount = 0;
    repeat (6*P) begin tick(); if (dout_valid) vcount++; end
    chk(vcount == 0, "R5 wrong spacing", vcount, 0);

    // R8: look-alike word at another offset while locked
    lock_up(0, 0, 0, 1000, "ghost");
    ghost_s = 49; ghost_from = 4*cyc; bad = 0;
    repeat (4*P) begin
      tick();
      if (!dout_valid || fsync || dout != exp_nib(cur, 0)) bad++;
    end
    chk(bad == 0, "R8 ghost word ignored", bad, 0);

    // R9: words stop after frame 3, lock drops on 4th missed check
    lock_up(2, 2, 0, 4, "loss");
    while (cyc <= 177) begin
      tick();
      if (cur == 176) chk(dout_valid, "R9 still locked after 3 misses", dout_valid, 1);
      if (cur == 177) chk(!dout_valid, "R9 unlocked after 4 misses", dout_valid, 0);
    end

    // R1 R2: loss of signal
    lock_up(1, 3, 1, 1000, "los");
    sig_det = 0; tick();
    chk(los, "R1 los pol=1 sig=0", los, 1);
    chk(dout == 4'h0, "R2 dout blanked", dout, 0);
    chk(!dout_valid, "R2 valid dropped", dout_valid, 0);
    bad = 0;
    repeat (3) begin tick(); if (dout != 4'h0) bad++; end
    chk(bad == 0, "R2 blank held", bad, 0);
    sig_det = 1; tick();
    chk(!los && !dout_valid, "R2 search after los", {los, dout_valid}, 0);
    det_pol = 0; sig_det = 1; tick();
    chk(los, "R1 los pol=0 sig=1", los, 1);
    sig_det = 0; tick();
    chk(!los, "R1 los clear pol=0 sig=0", los, 0);

    // R10: frame_en low from reset never locks
    s_base = 0; fb = 4*P; n_frames = 1000; ghost_from = 1 << 30;
    frame_en = 0; do_reset(); vcount = 0;
    repeat (5*P) begin tick(); if (dout_valid) vcount++; end
    chk(vcount == 0, "R10 no search when disabled", vcount, 0);

    // R10: frozen alignment while the stream shifts
    lock_up(1, 3, 0, 1000, "freeze");
    frame_en = 0; s_base = 3;
    tick(); tick();
    bad = 0;
    repeat (5*P) begin
      tick();
      if (!dout_valid || fsync || dout != exp_nib(cur, 3)) bad++;
    end
    chk(bad == 0, "R10 alignment held", bad, 0);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule